// File: doc/BRIEF.md
# Atomic-Launch Message Port

A processor-facing network port that makes message injection and message consumption atomic. Software builds an outgoing message in a small bank of staging words that it can read and write. Nothing reaches the network while it does so. A single launch command then streams the staged words out as one flit per accepted cycle, with the first flit marked head and the last marked tail. A half-built message can therefore be saved, restored or abandoned at any point before launch, for example across a context switch.

On the receive side, flits from the network are gathered into a single holding slot. A complete message is promoted into the visible receive registers as soon as they are free. It stays there, with an interrupt raised, until software issues a dispose command. Bit 31 of the first word of every message is the privilege flag: when it is set, the message raises the system interrupt instead of the user interrupt. The user interrupt can be masked so that software polls the status word instead.

Register map (5-bit word address): 0..7 staging words (RW); 8 send length (RW); 9 command (W: bit0 launch, bit1 dispose, bit2 clear overflow; reads 0); 10 status (R: bit0 sending, bit1 message present, bit2 overflow, bit3 privilege flag of the shown message, bits 7:4 shown length); 11 control (RW: bit0 user-interrupt mask); 16..23 received words (R).

Top module: `msg_port`

## Requirements
- R1: Writes to the staging words or the length register never assert tx_valid_o; tx_valid_o rises only in the cycle after an accepted launch command.
- R2: After a launch, exactly `length` flits leave in staging-word order, one per cycle in which tx_valid_o and tx_ready_i are both high. The first is marked head and the last tail, and a flit that is not accepted holds its data and marks.
- R3: A launch with length 0 sends nothing and leaves the port idle. A length write above 8 stores 8.
- R4: Staging words and the length register read back the values last written, so software can save and restore a partly built message.
- R5: While sending, writes to a staging word, to the length register, or a launch command are ignored and reg_err_o pulses in the next cycle. Other writes, such as a dispose, do not pulse reg_err_o.
- R6: A complete incoming message becomes visible two cycles after its tail flit when the receive registers are free. The status then shows present and the word count, the words read at 16 onward, and rx_irq_o is high for a user message.
- R7: A message whose first word has bit 31 set raises sys_irq_o and not rx_irq_o, and status bit 3 is set.
- R8: With control bit 0 set, rx_irq_o stays low while status still shows a present message; clearing the bit raises rx_irq_o again.
- R9: A shown message stays unchanged until a dispose command; a message waiting in the holding slot becomes visible only after that dispose.
- R10: A head flit arriving while a message is shown and the holding slot is full sets the sticky overflow bit, and the whole arriving message is dropped. Command bit 2 clears the bit.
- R11: After reset, no flit is offered, both interrupts and reg_err_o are low, and the status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| reg_err_o | output | 1 | One-cycle pulse after a rejected write |
| tx_valid_o | output | 1 | Outgoing flit valid |
| tx_ready_i | input | 1 | Network accepts outgoing flit |
| tx_data_o | output | 32 | Outgoing flit payload |
| tx_head_o | output | 1 | Outgoing flit is the first of its message |
| tx_tail_o | output | 1 | Outgoing flit is the last of its message |
| rx_valid_i | input | 1 | Incoming flit valid (always sunk) |
| rx_data_i | input | 32 | Incoming flit payload |
| rx_head_i | input | 1 | Incoming flit is a head |
| rx_tail_i | input | 1 | Incoming flit is a tail |
| rx_irq_o | output | 1 | User message present and not masked |
| sys_irq_o | output | 1 | Privileged message present |

## Verification
Launches are tried with lengths of one, three, eight and a saturating twelve. Each is drained under a different ready pattern: steady, alternating and in pairs. This separates ordering errors from stall handling and head or tail placement at both ends. A launch held by a stalled network shows that writes are refused mid-send and that the staged data survives. On the receive side, a run of four back-to-back messages fills the shown slot and the holding slot and then overflows. This tells promotion-on-dispose apart from overwriting and from silently losing a queued message. User, privileged and masked arrivals separate the two interrupt paths.

// File: rtl/msg_port_pkg.sv
package msg_port_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam logic [ADDR_W-1:0] A_LEN  = 5'h08;
  localparam logic [ADDR_W-1:0] A_CMD  = 5'h09;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h0A;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'h0B;
  localparam int unsigned RX_BIT    = 4;   // address bit selecting receive words
  localparam int unsigned CMD_LAUNCH  = 0;
  localparam int unsigned CMD_DISPOSE = 1;
  localparam int unsigned CMD_CLROVF  = 2;
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_PRES = 1;
  localparam int unsigned ST_OVF  = 2;
  localparam int unsigned ST_SYS  = 3;
  localparam int unsigned ST_LEN  = 4;
endpackage

// File: rtl/msg_tx.sv
module msg_tx #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 8,
  localparam int unsigned CW = $clog2(NW + 1),
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stage_we_i,
  input  logic [IW-1:0] stage_idx_i,
  input  logic          len_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          launch_i,
  output logic [DW-1:0] stage_o [NW],
  output logic [CW-1:0] len_o,
  output logic          busy_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_head_o,
  output logic          tx_tail_o
);
  logic [DW-1:0] stage_q [NW];
  logic [CW-1:0] len_q, idx_q;
  logic          busy_q, last;

  assign last = (idx_q == len_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) stage_q[i] <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (stage_we_i) stage_q[stage_idx_i] <= wdata_i;
      if (len_we_i) len_q <= (wdata_i > DW'(NW)) ? CW'(NW) : wdata_i[CW-1:0];
      if (!busy_q) begin
        if (launch_i && len_q != '0) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
        end
      end else if (tx_ready_i) begin
        if (last) busy_q <= 1'b0;
        else      idx_q  <= idx_q + CW'(1);
      end
    end
  end

  assign stage_o    = stage_q;
  assign len_o      = len_q;
  assign busy_o     = busy_q;
  assign tx_valid_o = busy_q;
  assign tx_data_o  = stage_q[idx_q[IW-1:0]];
  assign tx_head_o  = busy_q && (idx_q == '0);
  assign tx_tail_o  = busy_q && last;
endmodule

// File: rtl/msg_rx.sv
module msg_rx #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 8,
  localparam int unsigned CW = $clog2(NW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_head_i,
  input  logic          rx_tail_i,
  input  logic          dispose_i,
  input  logic          clr_ovf_i,
  output logic [DW-1:0] cur_o [NW],
  output logic [CW-1:0] cur_len_o,
  output logic          cur_present_o,
  output logic          cur_sys_o,
  output logic          ovf_o
);
  logic [DW-1:0] hold_q [NW];
  logic [DW-1:0] cur_q  [NW];
  logic [CW-1:0] hold_len_q, cur_len_q, wptr_q;
  logic          hold_full_q, cur_pres_q, drop_q, ovf_q;
  logic          promote, head_drop, room;

  assign promote   = hold_full_q && !cur_pres_q;
  assign head_drop = rx_head_i && hold_full_q && cur_pres_q;
  assign room      = (wptr_q < CW'(NW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) begin
        hold_q[i] <= '0;
        cur_q[i]  <= '0;
      end
      hold_len_q  <= '0;
      cur_len_q   <= '0;
      wptr_q      <= '0;
      hold_full_q <= 1'b0;
      cur_pres_q  <= 1'b0;
      drop_q      <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      if (dispose_i) cur_pres_q <= 1'b0;
      if (promote) begin
        cur_q       <= hold_q;
        cur_len_q   <= hold_len_q;
        cur_pres_q  <= 1'b1;
        hold_full_q <= 1'b0;
      end
      if (clr_ovf_i) ovf_q <= 1'b0;
      if (rx_valid_i) begin
        if (rx_head_i) begin
          if (head_drop) begin
            drop_q <= !rx_tail_i;
            ovf_q  <= 1'b1;
          end else begin
            drop_q    <= 1'b0;
            hold_q[0] <= rx_data_i;
            wptr_q    <= CW'(1);
            if (rx_tail_i) begin
              hold_len_q  <= CW'(1);
              hold_full_q <= 1'b1;
            end
          end
        end else if (drop_q) begin
          if (rx_tail_i) drop_q <= 1'b0;
        end else begin
          // words past the slot size are discarded, length saturates
          if (room) begin
            hold_q[wptr_q] <= rx_data_i;
            wptr_q         <= wptr_q + CW'(1);
          end
          if (rx_tail_i) begin
            hold_len_q  <= room ? wptr_q + CW'(1) : wptr_q;
            hold_full_q <= 1'b1;
          end
        end
      end
    end
  end

  assign cur_o         = cur_q;
  assign cur_len_o     = cur_len_q;
  assign cur_present_o = cur_pres_q;
  assign cur_sys_o     = cur_q[0][DW-1];
  assign ovf_o         = ovf_q;
endmodule

// File: rtl/msg_port.sv
module msg_port
  import msg_port_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MAX_WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_err_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_head_o,
  output logic              tx_tail_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_head_i,
  input  logic              rx_tail_i,
  output logic              rx_irq_o,
  output logic              sys_irq_o
);
  localparam int unsigned CW = $clog2(MAX_WORDS + 1);
  localparam int unsigned IW = $clog2(MAX_WORDS);

  logic [DATA_W-1:0] stage [MAX_WORDS];
  logic [DATA_W-1:0] cur   [MAX_WORDS];
  logic [CW-1:0]     len, cur_len;
  logic busy, cur_present, cur_sys, ovf;
  logic is_stage, is_len, is_cmd, is_stat, is_ctrl, is_rx, rx_in_range;
  logic send_wr, stage_we, len_we, launch, dispose, clr_ovf;
  logic mask_q, err_q;
  logic [DATA_W-1:0] status;

  assign is_stage    = reg_addr_i < ADDR_W'(MAX_WORDS);
  assign is_len      = reg_addr_i == A_LEN;
  assign is_cmd      = reg_addr_i == A_CMD;
  assign is_stat     = reg_addr_i == A_STAT;
  assign is_ctrl     = reg_addr_i == A_CTRL;
  assign is_rx       = reg_addr_i[RX_BIT];
  assign rx_in_range = reg_addr_i[RX_BIT-1:0] < RX_BIT'(MAX_WORDS);

  // writes that would disturb an in-flight send
  assign send_wr  = reg_wr_i && (is_stage || is_len || (is_cmd && reg_wdata_i[CMD_LAUNCH]));
  assign stage_we = reg_wr_i && is_stage && !busy;
  assign len_we   = reg_wr_i && is_len && !busy;
  assign launch   = reg_wr_i && is_cmd && reg_wdata_i[CMD_LAUNCH] && !busy;
  assign dispose  = reg_wr_i && is_cmd && reg_wdata_i[CMD_DISPOSE];
  assign clr_ovf  = reg_wr_i && is_cmd && reg_wdata_i[CMD_CLROVF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= send_wr && busy;
      if (reg_wr_i && is_ctrl) mask_q <= reg_wdata_i[0];
    end
  end

  msg_tx #(.DW(DATA_W), .NW(MAX_WORDS)) u_tx (
    .clk_i, .rst_ni,
    .stage_we_i (stage_we),
    .stage_idx_i(reg_addr_i[IW-1:0]),
    .len_we_i   (len_we),
    .wdata_i    (reg_wdata_i),
    .launch_i   (launch),
    .stage_o    (stage),
    .len_o      (len),
    .busy_o     (busy),
    .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_head_o, .tx_tail_o
  );

  msg_rx #(.DW(DATA_W), .NW(MAX_WORDS)) u_rx (
    .clk_i, .rst_ni,
    .rx_valid_i, .rx_data_i, .rx_head_i, .rx_tail_i,
    .dispose_i    (dispose),
    .clr_ovf_i    (clr_ovf),
    .cur_o        (cur),
    .cur_len_o    (cur_len),
    .cur_present_o(cur_present),
    .cur_sys_o    (cur_sys),
    .ovf_o        (ovf)
  );

  always_comb begin
    status              = '0;
    status[ST_BUSY]     = busy;
    status[ST_PRES]     = cur_present;
    status[ST_OVF]      = ovf;
    status[ST_SYS]      = cur_present && cur_sys;
    status[ST_LEN+:CW]  = cur_present ? cur_len : '0;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (is_rx) begin
      if (rx_in_range) reg_rdata_o = cur[reg_addr_i[IW-1:0]];
    end else if (is_stage) reg_rdata_o = stage[reg_addr_i[IW-1:0]];
    else if (is_len)       reg_rdata_o = DATA_W'(len);
    else if (is_stat)      reg_rdata_o = status;
    else if (is_ctrl)      reg_rdata_o = DATA_W'(mask_q);
  end

  assign reg_err_o = err_q;
  assign rx_irq_o  = cur_present && !cur_sys && !mask_q;
  assign sys_irq_o = cur_present && cur_sys;
endmodule

// File: rtl/msg_port_chk.sv
module msg_port_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_head_o,
  input logic              tx_tail_o,
  input logic              reg_err_o,
  input logic              rx_irq_o,
  input logic              sys_irq_o,
  input logic              rx_valid_i,
  input logic              rx_head_i,
  input logic              launch,
  input logic              dispose,
  input logic              cur_present,
  input logic              ovf
);
  a_r1_launch_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(launch));

  a_r2_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
                                  && $stable(tx_head_o) && $stable(tx_tail_o));

  a_r2_tail_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_tail_o |=> !tx_valid_o);

  a_r5_err_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> $past(tx_valid_o));

  a_r7_irq_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_irq_o && sys_irq_o));

  a_r9_held_to_dispose: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_present && !dispose |=> cur_present);

  a_r10_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf) |-> $past(rx_valid_i && rx_head_i && cur_present));
endmodule

bind msg_port msg_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_head_o, .tx_tail_o,
  .reg_err_o, .rx_irq_o, .sys_irq_o, .rx_valid_i, .rx_head_i,
  .launch(launch), .dispose(dispose), .cur_present(cur_present), .ovf(ovf)
);

// File: tb/msg_port_test.sv
`timescale 1ns/1ps
module msg_port_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        reg_err_o, tx_valid_o, tx_ready_i = 1'b0, tx_head_o, tx_tail_o;
  logic [31:0] tx_data_o, rx_data_i = '0;
  logic        rx_valid_i = 1'b0, rx_head_i = 1'b0, rx_tail_i = 1'b0;
  logic        rx_irq_o, sys_irq_o;

  msg_port uut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic last_err;
  logic [31:0] exp_w [8];

  // len[31:24] seed[23:16] ready pattern[15:0]
  localparam logic [31:0] VEC [4] = '{
    {8'd1,  8'h11, 16'hFFFF},
    {8'd3,  8'h22, 16'h5555},
    {8'd8,  8'h33, 16'h3333},
    {8'd12, 8'h44, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    #1 last_err = reg_err_o;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // drains n flits against exp_w under a ready pattern
  task automatic drain(input int n, input logic [15:0] pat, input string req);
    int got = 0;
    for (int k = 0; k < 64 && got < n; k++) begin
      @(negedge clk_i);
      tx_ready_i = pat[k % 16];
      #1;
      if (tx_valid_o && tx_ready_i) begin
        chk(req, tx_data_o, exp_w[got]);
        chk(req, {30'd0, tx_head_o, tx_tail_o}, {30'd0, got == 0, got == n - 1});
        got++;
      end
    end
    chk(req, got, n);
    @(negedge clk_i);
    tx_ready_i = 1'b0;
    #1 chk(req, {31'd0, tx_valid_o}, 32'd0);
  endtask

  task automatic rx_msg(input logic [31:0] base, input int n, input bit sys);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      rx_valid_i = 1'b1;
      rx_data_i  = (i == 0) ? {sys, base[30:0]} : base + 32'(i);
      rx_head_i  = (i == 0);
      rx_tail_i  = (i == n - 1);
    end
    @(negedge clk_i);
    rx_valid_i = 1'b0; rx_head_i = 1'b0; rx_tail_i = 1'b0;
    idle(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    idle(2);
    // R11 reset state
    #1;
    chk("R11", {29'd0, tx_valid_o, rx_irq_o, sys_irq_o}, 32'd0);
    chk("R11", {31'd0, reg_err_o}, 32'd0);
    rst_ni = 1'b1;
    rd(5'h0A, d); chk("R11", d, 32'd0);

    // R1 / R4 staging writes stay local and read back
    for (int i = 0; i < 8; i++) begin
      wr(5'(i), 32'hBEEF_0000 + 32'(i));
      chk("R1", {31'd0, tx_valid_o}, 32'd0);
    end
    wr(5'h08, 32'd5);
    chk("R1", {31'd0, tx_valid_o}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(5'(i), d); chk("R4", d, 32'hBEEF_0000 + 32'(i));
    end
    rd(5'h08, d); chk("R4", d, 32'd5);

    // R2 / R3 table of launches
    for (int v = 0; v < 4; v++) begin
      int n;
      n = (VEC[v][31:24] > 8) ? 8 : int'(VEC[v][31:24]);
      for (int i = 0; i < 8; i++) begin
        exp_w[i] = {VEC[v][23:16], 8'(i), 16'hA5C3};
        wr(5'(i), exp_w[i]);
      end
      wr(5'h08, 32'(VEC[v][31:24]));
      rd(5'h08, d); chk("R3", d, 32'(n));
      wr(5'h09, 32'h1);
      drain(n, VEC[v][15:0], "R2");
    end

    // R3 zero-length launch
    wr(5'h08, 32'd0);
    wr(5'h09, 32'h1);
    idle(3);
    #1 chk("R3", {31'd0, tx_valid_o}, 32'd0);
    rd(5'h0A, d); chk("R3", d & 32'h1, 32'd0);

    // R5 writes refused mid-send
    for (int i = 0; i < 4; i++) begin
      exp_w[i] = 32'h0000_1000 + 32'(i);
      wr(5'(i), exp_w[i]);
    end
    wr(5'h08, 32'd4);
    tx_ready_i = 1'b0;
    wr(5'h09, 32'h1);
    chk("R5", {31'd0, tx_valid_o}, 32'd1);
    wr(5'h00, 32'hDEAD_DEAD); chk("R5", {31'd0, last_err}, 32'd1);
    rd(5'h00, d); chk("R5", d, 32'h0000_1000);
    wr(5'h08, 32'd2); chk("R5", {31'd0, last_err}, 32'd1);
    rd(5'h08, d); chk("R5", d, 32'd4);
    wr(5'h09, 32'h1); chk("R5", {31'd0, last_err}, 32'd1);
    wr(5'h09, 32'h2); chk("R5", {31'd0, last_err}, 32'd0);
    drain(4, 16'hFFFF, "R5");

    // R6 user message arrives
    rx_msg(32'h0000_0A00, 3, 1'b0);
    rd(5'h0A, d); chk("R6", d, 32'h32);
    chk("R6", {30'd0, rx_irq_o, sys_irq_o}, 32'd2);
    rd(5'h10, d); chk("R6", d, 32'h0000_0A00);
    rd(5'h12, d); chk("R6", d, 32'h0000_0A02);

    // R9 second message waits for dispose
    rx_msg(32'h0000_0B00, 2, 1'b0);
    rd(5'h10, d); chk("R9", d, 32'h0000_0A00);
    wr(5'h09, 32'h2); idle(2);
    rd(5'h10, d); chk("R9", d, 32'h0000_0B00);
    rd(5'h0A, d); chk("R9", d, 32'h22);

    // R10 holding slot full, fourth message dropped
    rx_msg(32'h0000_0C00, 4, 1'b0);
    rd(5'h0A, d); chk("R10", d & 32'h4, 32'd0);
    rx_msg(32'h0000_0D00, 2, 1'b0);
    rd(5'h0A, d); chk("R10", d & 32'h4, 32'h4);
    wr(5'h09, 32'h2); idle(2);
    rd(5'h10, d); chk("R10", d, 32'h0000_0C00);
    rd(5'h13, d); chk("R10", d, 32'h0000_0C03);
    wr(5'h09, 32'h2); idle(2);
    rd(5'h0A, d); chk("R10", d & 32'h2, 32'd0);
    wr(5'h09, 32'h4);
    rd(5'h0A, d); chk("R10", d, 32'd0);

    // R7 privileged message
    rx_msg(32'h0000_0E00, 1, 1'b1);
    chk("R7", {30'd0, rx_irq_o, sys_irq_o}, 32'd1);
    rd(5'h0A, d); chk("R7", d, 32'h1A);
    wr(5'h09, 32'h2); idle(2);
    chk("R7", {30'd0, rx_irq_o, sys_irq_o}, 32'd0);

    // R8 masked user interrupt
    wr(5'h0B, 32'h1);
    rx_msg(32'h0000_0F00, 2, 1'b0);
    chk("R8", {30'd0, rx_irq_o, sys_irq_o}, 32'd0);
    rd(5'h0A, d); chk("R8", d & 32'h2, 32'h2);
    wr(5'h0B, 32'h0);
    chk("R8", {31'd0, rx_irq_o}, 32'd1);
    wr(5'h09, 32'h2); idle(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule